// File: doc/BRIEF.md
# Associative Page Translation Cache with Access Rights

This block keeps a small set of recent page mappings and turns a virtual page number into a physical frame number. Each slot holds these fields:

- a valid flag
- the virtual page tag
- a modified flag
- read, write and execute rights
- the frame number

A lookup compares the incoming page against every slot at once. A hit answers one cycle after the request. The answer carries the frame, or a fault flag when the access kind is not allowed by the slot's rights.

On a miss the block holds the request and raises a refill request to an outside page-table source. When that source returns the mapping, the block writes it into one slot and answers as if the lookup had hit. If the chosen slot was in use, its tag and modified flag are sent out on a write-back port, so the page table can record whether the page was written. A write that is allowed sets the slot's modified flag.

A flush input drops every mapping in one cycle without any write-back.

Top module: `xlat_cache`

## Requirements
- R1: With the default of 8 slots, a request (reqValid high while missReq is low) whose page matches a valid slot, and whose access is allowed, gives respValid high, respFault low and respPfn equal to the slot's frame on the following cycle, with missReq staying low.
- R2: Access kind encoding is 00 read, 01 write, 10 execute, 11 read. Read needs the read right, write needs the write right, execute needs the execute right. In refillPerm the read right is bit 2, write is bit 1 and execute is bit 0. A hit that breaks the rights gives respFault high and respPfn zero, and it does not set the modified flag.
- R3: Only valid slots take part in matching. After a flush, a page that was held before misses.
- R4: A request that matches no valid slot raises missReq on the next cycle, with missVpn equal to the requested page and no response. missReq stays high, with missVpn unchanged, until refillValid. A reqValid raised while missReq is high has no effect.
- R5: In the cycle after refillValid, respValid is high and missReq is low. The response is judged against the refilled rights: the refilled frame when allowed, otherwise a fault with frame zero. The refilled mapping then hits on later lookups.
- R6: An allowed write hit sets the slot's modified flag. A refill for an allowed write installs the modified flag as 1; otherwise it installs the refillDirty input.
- R7: The slot replaced is the lowest-numbered invalid slot. When all slots are valid, it is the slot named by a rotating pointer. The pointer is 0 after reset and advances by one, wrapping, each time it is used.
- R8: When a refill replaces a valid slot, wbValid pulses high for one cycle in the cycle after refillValid. In that cycle wbVpn and wbDirty carry the old slot's tag and modified flag. Filling an invalid slot gives no pulse.
- R9: flushAll clears every valid flag in one cycle and never causes a wbValid pulse.
- R10: After reset all slots are invalid, the rotating pointer is 0, and respValid, respFault, missReq and wbValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flushAll | input | 1 | Drop every mapping this cycle |
| reqValid | input | 1 | Lookup request strobe |
| reqVpn | input | VPN_W | Requested virtual page |
| reqKind | input | 2 | Access kind (00 read, 01 write, 10 exec, 11 read) |
| respValid | output | 1 | Response strobe |
| respFault | output | 1 | Access breaks the rights |
| respPfn | output | PFN_W | Frame number, zero on fault |
| missReq | output | 1 | Refill wanted for missVpn |
| missVpn | output | VPN_W | Page to fetch |
| refillValid | input | 1 | Refill data present |
| refillPfn | input | PFN_W | Refilled frame |
| refillPerm | input | 3 | Refilled rights {read, write, exec} |
| refillDirty | input | 1 | Refilled modified flag |
| wbValid | output | 1 | Evicted slot report strobe |
| wbVpn | output | VPN_W | Evicted page tag |
| wbDirty | output | 1 | Evicted modified flag |

## Verification
The properties assume a well-behaved requester and refill source. refillValid arrives only while missReq is high. The refill always describes the page on missVpn, so one page never sits in two slots. Under those terms, a lone request matches at most one slot.

The bench keeps within these terms. It raises refillValid only after seeing missReq, and it tracks every page it has installed. It asks for pages from a small pool, so hits and evictions are both common. It raises flushAll only between transactions, and raises reqValid during a pending miss only as a deliberate probe with a page outside the pool.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_ALT   = 2'b11
  } accKind_t;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } perm_t;

  // strobes from control to the slot datapath
  typedef struct packed {
    logic respHit;
    logic capture;
    logic markDirty;
    logic install;
    logic flush;
  } ctrlStrobe_t;

  function automatic logic permOk(input logic [1:0] kind, input perm_t p);
    case (kind)
      ACC_WRITE: return p.wr;
      ACC_EXEC:  return p.ex;
      default:   return p.rd;
    endcase
  endfunction

endpackage

// File: rtl/xlat_entries.sv
module xlat_entries
  import xlat_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int VPN_W = 8,
  parameter int PFN_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      st,
  input  logic [VPN_W-1:0] reqVpn,
  input  logic [1:0]       reqKind,
  input  logic [PFN_W-1:0] refillPfn,
  input  perm_t            refillPerm,
  input  logic             refillDirty,
  output logic             hit,
  output logic             hitOk,
  output logic [VPN_W-1:0] heldVpn,
  output logic             respValid,
  output logic             respFault,
  output logic [PFN_W-1:0] respPfn,
  output logic             wbValid,
  output logic [VPN_W-1:0] wbVpn,
  output logic             wbDirty
);

  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic [NUM_ENTRIES-1:0] valid;
  logic [NUM_ENTRIES-1:0] dirty;
  logic [VPN_W-1:0]       vpnTab [NUM_ENTRIES];
  logic [PFN_W-1:0]       pfnTab [NUM_ENTRIES];
  perm_t                  permTab [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]       hitIdx;
  logic [IDX_W-1:0]       freeIdx;
  logic [IDX_W-1:0]       victim;
  logic [IDX_W-1:0]       rrPtr;
  logic                   anyFree;
  logic [1:0]             heldKind;
  logic                   refillOk;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_match
    assign matchVec[g] = valid[g] && (vpnTab[g] == reqVpn);
  end

  assign hit = |matchVec;
  assign anyFree = ~&valid;

  always_comb begin
    hitIdx = '0;
    freeIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) hitIdx = IDX_W'(i);
      if (!valid[i]) freeIdx = IDX_W'(i);
    end
  end

  assign victim = anyFree ? freeIdx : rrPtr;
  assign hitOk = permOk(reqKind, permTab[hitIdx]);
  assign refillOk = permOk(heldKind, refillPerm);

  // state flags with reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid <= '0;
      dirty <= '0;
      rrPtr <= '0;
    end else begin
      if (st.flush) valid <= '0;
      if (st.markDirty) dirty[hitIdx] <= 1'b1;
      if (st.install) begin
        valid[victim] <= 1'b1;
        dirty[victim] <= refillDirty || ((heldKind == ACC_WRITE) && refillPerm.wr);
        if (!anyFree) rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
      end
    end
  end

  // payload without reset
  always_ff @(posedge clk) begin
    if (st.install) begin
      vpnTab[victim]  <= heldVpn;
      pfnTab[victim]  <= refillPfn;
      permTab[victim] <= refillPerm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldVpn  <= '0;
      heldKind <= '0;
    end else if (st.capture) begin
      heldVpn  <= reqVpn;
      heldKind <= reqKind;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respFault <= 1'b0;
      respPfn   <= '0;
    end else begin
      respValid <= st.respHit || st.install;
      respFault <= 1'b0;
      respPfn   <= '0;
      if (st.respHit) begin
        respFault <= !hitOk;
        respPfn   <= hitOk ? pfnTab[hitIdx] : '0;
      end else if (st.install) begin
        respFault <= !refillOk;
        respPfn   <= refillOk ? refillPfn : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbValid <= 1'b0;
      wbVpn   <= '0;
      wbDirty <= 1'b0;
    end else begin
      wbValid <= st.install && !anyFree;
      if (st.install) begin
        wbVpn   <= vpnTab[victim];
        wbDirty <= dirty[victim];
      end
    end
  end

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        flushAll,
  input  logic        reqValid,
  input  logic [1:0]  reqKind,
  input  logic        hit,
  input  logic        hitOk,
  input  logic        refillValid,
  output ctrlStrobe_t st,
  output logic        missReq
);

  typedef enum logic {S_IDLE, S_WAIT} state_t;
  state_t state;
  state_t stateNext;

  always_comb begin
    st.respHit   = (state == S_IDLE) && reqValid && hit;
    st.capture   = (state == S_IDLE) && reqValid && !hit;
    st.markDirty = st.respHit && (reqKind == ACC_WRITE) && hitOk;
    st.install   = (state == S_WAIT) && refillValid;
    st.flush     = flushAll;
    stateNext = state;
    if (st.capture) stateNext = S_WAIT;
    if (st.install) stateNext = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign missReq = (state == S_WAIT);

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int VPN_W = 8,
  parameter int PFN_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flushAll,
  input  logic             reqValid,
  input  logic [VPN_W-1:0] reqVpn,
  input  logic [1:0]       reqKind,
  output logic             respValid,
  output logic             respFault,
  output logic [PFN_W-1:0] respPfn,
  output logic             missReq,
  output logic [VPN_W-1:0] missVpn,
  input  logic             refillValid,
  input  logic [PFN_W-1:0] refillPfn,
  input  logic [2:0]       refillPerm,
  input  logic             refillDirty,
  output logic             wbValid,
  output logic [VPN_W-1:0] wbVpn,
  output logic             wbDirty
);

  ctrlStrobe_t st;
  logic hit;
  logic hitOk;

  xlat_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .flushAll(flushAll), .reqValid(reqValid),
    .reqKind(reqKind), .hit(hit), .hitOk(hitOk), .refillValid(refillValid),
    .st(st), .missReq(missReq)
  );

  xlat_entries #(.NUM_ENTRIES(NUM_ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) uData (
    .clk(clk), .rstN(rstN), .st(st), .reqVpn(reqVpn), .reqKind(reqKind),
    .refillPfn(refillPfn), .refillPerm(perm_t'(refillPerm)), .refillDirty(refillDirty),
    .hit(hit), .hitOk(hitOk), .heldVpn(missVpn), .respValid(respValid),
    .respFault(respFault), .respPfn(respPfn), .wbValid(wbValid),
    .wbVpn(wbVpn), .wbDirty(wbDirty)
  );

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VPN_W = 8,
  parameter int PFN_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             flushAll,
  input logic             reqValid,
  input logic             respValid,
  input logic             respFault,
  input logic [PFN_W-1:0] respPfn,
  input logic             missReq,
  input logic [VPN_W-1:0] missVpn,
  input logic             refillValid,
  input logic             wbValid
);

  a_r1_answer_or_miss: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !missReq |=> respValid || missReq);

  a_r2_fault_zero_frame: assert property (@(posedge clk) disable iff (!rstN)
    respFault |-> respValid && (respPfn == '0));

  a_r4_miss_held: assert property (@(posedge clk) disable iff (!rstN)
    missReq && !refillValid |=> missReq && $stable(missVpn));

  a_r5_refill_answers: assert property (@(posedge clk) disable iff (!rstN)
    missReq && refillValid |=> respValid && !missReq);

  a_r8_wb_after_refill: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> $past(missReq && refillValid));

  a_r9_flush_no_wb: assert property (@(posedge clk) disable iff (!rstN)
    flushAll && !missReq |=> !wbValid);

endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W)) uChk (
  .clk(clk), .rstN(rstN), .flushAll(flushAll), .reqValid(reqValid),
  .respValid(respValid), .respFault(respFault), .respPfn(respPfn),
  .missReq(missReq), .missVpn(missVpn), .refillValid(refillValid),
  .wbValid(wbValid)
);

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
  localparam int N = 8;
  localparam int VW = 8;
  localparam int PW = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, flushAll, reqValid, refillValid, refillDirty;
  logic [VW-1:0] reqVpn;
  logic [1:0] reqKind;
  logic [PW-1:0] refillPfn;
  logic [2:0] refillPerm;
  logic respValid, respFault, missReq, wbValid, wbDirty;
  logic [PW-1:0] respPfn;
  logic [VW-1:0] missVpn, wbVpn;

  xlat_cache #(.NUM_ENTRIES(N), .VPN_W(VW), .PFN_W(PW)) u0 (
    .clk(clk), .rstN(rstN), .flushAll(flushAll), .reqValid(reqValid),
    .reqVpn(reqVpn), .reqKind(reqKind), .respValid(respValid),
    .respFault(respFault), .respPfn(respPfn), .missReq(missReq),
    .missVpn(missVpn), .refillValid(refillValid), .refillPfn(refillPfn),
    .refillPerm(refillPerm), .refillDirty(refillDirty), .wbValid(wbValid),
    .wbVpn(wbVpn), .wbDirty(wbDirty)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit mValid[N];
  bit mDirty[N];
  int mVpn[N];
  int mPfn[N];
  int mPerm[N];
  int mPtr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // perm bits: [2] read, [1] write, [0] execute
  function automatic bit allowed(input int kind, input int perm);
    if (kind == 1) return perm[1];
    if (kind == 2) return perm[0];
    return perm[2];
  endfunction

  function automatic int findHit(input int vpn);
    for (int i = 0; i < N; i++)
      if (mValid[i] && mVpn[i] == vpn) return i;
    return -1;
  endfunction

  task automatic lookup(input int vpn, input int kind, input int rPfn, input int rPerm,
                        input bit rDirty, input bit probe, output bit wasMiss);
    int h;
    int v;
    bit ok;
    bit evict;
    @(negedge clk);
    reqValid = 1; reqVpn = VW'(vpn); reqKind = 2'(kind);
    @(negedge clk);
    reqValid = 0;
    h = findHit(vpn);
    wasMiss = missReq;
    if (h >= 0) begin
      ok = allowed(kind, mPerm[h]);
      chk(respValid == 1, "R1 hit response", int'(respValid), 1);
      chk(missReq == 0, "R1 no miss on hit", int'(missReq), 0);
      chk(int'(respFault) == int'(!ok), "R2 fault flag", int'(respFault), int'(!ok));
      chk(int'(respPfn) == (ok ? mPfn[h] : 0), "R1 frame", int'(respPfn), ok ? mPfn[h] : 0);
      if (ok && kind == 1) mDirty[h] = 1;
    end else begin
      chk(missReq == 1, "R4 miss raised", int'(missReq), 1);
      chk(int'(missVpn) == vpn, "R4 miss page", int'(missVpn), vpn);
      chk(respValid == 0, "R4 no response on miss", int'(respValid), 0);
      if (probe) begin
        reqValid = 1; reqVpn = VW'(vpn ^ 8'h80); reqKind = 2'b00;
        @(negedge clk);
        reqValid = 0;
        chk(respValid == 0, "R4 request ignored while missing", int'(respValid), 0);
        chk(missReq == 1 && int'(missVpn) == vpn, "R4 miss held", int'(missVpn), vpn);
      end
      refillValid = 1; refillPfn = PW'(rPfn); refillPerm = 3'(rPerm); refillDirty = rDirty;
      @(negedge clk);
      refillValid = 0;
      v = -1;
      for (int i = N - 1; i >= 0; i--) if (!mValid[i]) v = i;
      evict = (v < 0);
      if (evict) v = mPtr;
      ok = allowed(kind, rPerm);
      chk(respValid == 1, "R5 refill response", int'(respValid), 1);
      chk(missReq == 0, "R5 miss dropped", int'(missReq), 0);
      chk(int'(respFault) == int'(!ok), "R5 refill fault", int'(respFault), int'(!ok));
      chk(int'(respPfn) == (ok ? rPfn : 0), "R5 refill frame", int'(respPfn), ok ? rPfn : 0);
      chk(int'(wbValid) == int'(evict), "R8 write-back strobe", int'(wbValid), int'(evict));
      if (evict) begin
        chk(int'(wbVpn) == mVpn[v], "R7 victim choice", int'(wbVpn), mVpn[v]);
        chk(int'(wbDirty) == int'(mDirty[v]), "R6 R8 modified write-back", int'(wbDirty), int'(mDirty[v]));
        mPtr = (mPtr + 1) % N;
      end
      mValid[v] = 1; mVpn[v] = vpn; mPfn[v] = rPfn; mPerm[v] = rPerm;
      mDirty[v] = rDirty || (kind == 1 && rPerm[1]);
    end
  endtask

  task automatic flush();
    @(negedge clk);
    flushAll = 1;
    @(negedge clk);
    flushAll = 0;
    chk(wbValid == 0, "R9 no write-back on flush", int'(wbValid), 0);
    for (int i = 0; i < N; i++) mValid[i] = 0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R4 act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit m;
    void'($urandom(32'd4242));
    rstN = 0; flushAll = 0; reqValid = 0; reqVpn = '0; reqKind = '0;
    refillValid = 0; refillPfn = '0; refillPerm = '0; refillDirty = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(respValid == 0 && respFault == 0, "R10 reset response", int'(respValid), 0);
    chk(missReq == 0 && wbValid == 0, "R10 reset miss/wb", int'(missReq), 0);

    // fill all slots, each miss first (R10 empty, R7 lowest invalid)
    for (int i = 0; i < N; i++) lookup(i, 0, 10 + i, 7, 0, i == 2, m);
    // R6: allowed write hit marks slot 3
    lookup(3, 1, 0, 0, 0, 0, m);
    // R2: read-only slot, write faults, no mark
    lookup(40, 0, 33, 4, 0, 0, m);
    lookup(40, 1, 0, 0, 0, 0, m);
    lookup(40, 2, 0, 0, 0, 0, m);
    lookup(40, 3, 0, 0, 0, 0, m);
    // R7 R8: rotate through all slots, see modified flags leave
    for (int i = 0; i < N; i++) lookup(20 + i, 0, 50 + i, 6, 0, 0, m);
    // R9 R3: flush then a held page misses
    flush();
    lookup(21, 0, 5, 7, 1, 0, m);
    chk(m == 1, "R3 flushed slot not matched", int'(m), 1);
    lookup(21, 1, 0, 0, 0, 0, m);
    chk(m == 0, "R5 refilled mapping hits", int'(m), 0);

    for (int it = 0; it < 500; it++) begin
      if ($urandom % 60 == 0) flush();
      lookup($urandom % 16, $urandom % 4, $urandom % 64, $urandom % 8,
             1'($urandom % 2), ($urandom % 5) == 0, m);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule